// File: doc/BRIEF.md
# Deep-Sleep Entry and Wake Sequencer

This block sequences the deepest power-saving state of a small microcontroller. Software writes a control word that carries a sleep request bit, a release-style bit and a warm-up length select. Once the request bit is set, the block shuts the main oscillator off and pulses a clear to the prescaler and timing divider. It then waits for a wake condition, and after that runs a warm-up count so that the oscillator can settle. At the end of the warm-up it hands control back to the processor and reports completion.

There are two release styles. In level style, the sleep state ends while the dedicated wake pin is high, or while any enabled key input is low. If such a condition already holds when sleep is requested, the block skips the sleep state and goes straight to warm-up. In edge style, only a fresh rising edge on the wake pin ends the sleep state, and the key inputs play no part. The wake pin cannot be masked in either style. Every external wake input passes through a two-flop synchronizer. The whole block runs on a free-running low-rate wake clock, and the oscillator-enable output controls the main clock.

The processor side uses the hold output to stall instruction fetch. It uses the ready pulse to learn that the wake-up has finished.

Top module: `deep_sleep_seq`

## Requirements
- R1: After reset, `osc_en` is 1, and `cpu_hold`, `wake_ready`, `presc_clr` and `stop_bit` are all 0.
- R2: A control write with the sleep bit set, made while idle and with no level-style release pending, brings `osc_en` to 0 and `cpu_hold` to 1 on the clock edge after `stop_bit` becomes visible. On that same edge `presc_clr` rises for exactly one cycle.
- R3: In level style (release-style bit = 1), the sleep state ends when the synchronized wake pin is high. It also ends when any key input whose enable bit is 1 is low (key inputs are active-low).
- R4: In level style, if a release condition holds when the request is seen, `osc_en` never drops, `presc_clr` never pulses, and warm-up starts at once.
- R5: A key input whose enable bit is 0 never ends the sleep state.
- R6: In edge style (release-style bit = 0), only a rising edge of the synchronized wake pin seen while asleep ends the sleep state. A pin that was already high at entry, or one that falls, does not end it.
- R7: In edge style, key inputs have no effect, whatever their enables.
- R8: Warm-up lasts exactly 2^(8+2*sel) wake-clock cycles, where sel is the 2-bit select (sel 0 gives 256 and sel 3 gives 16384). During warm-up `osc_en` is 1 and `cpu_hold` is 1.
- R9: `wake_ready` is a one-cycle pulse in the first cycle after warm-up, with `cpu_hold` already 0. `stop_bit` reads 0 from that cycle on, so the block stays idle.
- R10: A control write made while `cpu_hold` is 1 (asleep or warming up) is ignored. It changes neither the release style nor the warm-up select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running low-rate wake clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_stop | input | 1 | Sleep request bit of the control word |
| cfg_level | input | 1 | Release style: 1 level, 0 edge |
| cfg_wsel | input | 2 | Warm-up length select |
| key_en | input | NKEY (4) | Per-key wake enable bits |
| wake_pin | input | 1 | Asynchronous dedicated wake pin, never masked |
| key_n | input | NKEY (4) | Asynchronous active-low key wake inputs |
| osc_en | output | 1 | Main oscillator enable |
| presc_clr | output | 1 | One-cycle clear to prescaler and timing divider |
| cpu_hold | output | 1 | Stall flag for instruction fetch |
| wake_ready | output | 1 | One-cycle pulse when warm-up is complete |
| stop_bit | output | 1 | Read-back of the sleep request bit |

## Verification
The assertions take it that the control word is written only through `cfg_wr`, and that the wake inputs stay steady long enough for the two-flop synchronizers to pass them. They also take it that the key enables are steady for as long as the block is asleep. The stimulus changes the wake pin and the keys at falling edges and holds every level for many cycles. It changes `key_en` only while idle, and it waits for the synchronizer delay before it relies on a new input level. The checks that cover the sleep state look only at cycles in which the oscillator is already off. This keeps them clear of the entry cycle.

// File: rtl/stopc_pkg.sv
package stopc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } stopc_state_e;
endpackage

// File: rtl/wk_sync.sv
// Two-flop synchronizer for a vector of asynchronous wake inputs.
module wk_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/wk_release.sv
// Builds the level-style release term and the wake pin rising-edge term.
module wk_release #(
  parameter int NKEY = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_s,
  input  logic [NKEY-1:0] key_s_n,
  input  logic [NKEY-1:0] key_en,
  output logic            lvl_rel,
  output logic            pin_rise
);
  logic            pin_d;
  logic [NKEY-1:0] key_hit;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  // One term per key: enabled and driven low.
  for (genvar k = 0; k < NKEY; k++) begin : g_key
    assign key_hit[k] = key_en[k] & ~key_s_n[k];
  end

  assign lvl_rel  = pin_s | (|key_hit);
  assign pin_rise = pin_s & ~pin_d;
endmodule

// File: rtl/wk_warmup.sv
// Warm-up down-counter whose load value is 2^(BASE_LOG + STEP_LOG*sel) - 1.
module wk_warmup #(
  parameter int SELW     = 2,
  parameter int BASE_LOG = 8,
  parameter int STEP_LOG = 2,
  parameter int CNTW     = BASE_LOG + STEP_LOG * ((1 << SELW) - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            run,
  input  logic [SELW-1:0] sel,
  output logic            zero
);
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] load_val;
  int              shamt;

  always_comb begin
    shamt    = BASE_LOG + STEP_LOG * int'(sel);
    load_val = CNTW'((64'(1) << shamt) - 64'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/deep_sleep_seq.sv
module deep_sleep_seq
  import stopc_pkg::*;
#(
  parameter int NKEY        = 4,
  parameter int WSEL_W      = 2,
  parameter int WU_BASE_LOG = 8,
  parameter int WU_STEP_LOG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_stop,
  input  logic              cfg_level,
  input  logic [WSEL_W-1:0] cfg_wsel,
  input  logic [NKEY-1:0]   key_en,
  input  logic              wake_pin,
  input  logic [NKEY-1:0]   key_n,
  output logic              osc_en,
  output logic              presc_clr,
  output logic              cpu_hold,
  output logic              wake_ready,
  output logic              stop_bit
);
  localparam int CNTW = WU_BASE_LOG + WU_STEP_LOG * ((1 << WSEL_W) - 1);

  stopc_state_e      state, nstate;
  logic              level_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              pin_s;
  logic [NKEY-1:0]   key_s_n;
  logic              lvl_rel, pin_rise;
  logic              wu_load, wu_zero;
  logic              accept_wr;

  wk_sync #(.W(1), .RST_VAL(1'b0)) i_pin_sync (
    .clk(clk), .rst(rst), .d_async(wake_pin), .d_sync(pin_s)
  );

  wk_sync #(.W(NKEY), .RST_VAL({NKEY{1'b1}})) i_key_sync (
    .clk(clk), .rst(rst), .d_async(key_n), .d_sync(key_s_n)
  );

  wk_release #(.NKEY(NKEY)) i_rel (
    .clk(clk), .rst(rst), .pin_s(pin_s), .key_s_n(key_s_n),
    .key_en(key_en), .lvl_rel(lvl_rel), .pin_rise(pin_rise)
  );

  wk_warmup #(
    .SELW(WSEL_W), .BASE_LOG(WU_BASE_LOG), .STEP_LOG(WU_STEP_LOG), .CNTW(CNTW)
  ) i_wu (
    .clk(clk), .rst(rst), .load(wu_load), .run(state == ST_WARM),
    .sel(wsel_q), .zero(wu_zero)
  );

  // The control word is accepted only while the core is running.
  assign accept_wr = cfg_wr && (state == ST_RUN);

  always_comb begin
    nstate  = state;
    wu_load = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (stop_bit) begin
          if (level_q && lvl_rel) begin
            nstate  = ST_WARM;
            wu_load = 1'b1;
          end else begin
            nstate = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (level_q ? lvl_rel : pin_rise) begin
          nstate  = ST_WARM;
          wu_load = 1'b1;
        end
      end
      ST_WARM: begin
        if (wu_zero) nstate = ST_RUN;
      end
      default: nstate = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      osc_en     <= 1'b1;
      cpu_hold   <= 1'b0;
      presc_clr  <= 1'b0;
      wake_ready <= 1'b0;
      stop_bit   <= 1'b0;
      level_q    <= 1'b0;
      wsel_q     <= '0;
    end else begin
      state      <= nstate;
      osc_en     <= (nstate != ST_STOP);
      cpu_hold   <= (nstate != ST_RUN);
      presc_clr  <= (state == ST_RUN) && (nstate == ST_STOP);
      wake_ready <= (state == ST_WARM) && (nstate == ST_RUN);
      if ((state == ST_WARM) && (nstate == ST_RUN)) stop_bit <= 1'b0;
      else if (accept_wr)                           stop_bit <= cfg_stop;
      if (accept_wr) begin
        level_q <= cfg_level;
        wsel_q  <= cfg_wsel;
      end
    end
  end
endmodule

// File: rtl/deep_sleep_seq_chk.sv
module deep_sleep_seq_chk #(
  parameter int NKEY   = 4,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              osc_en,
  input logic              presc_clr,
  input logic              cpu_hold,
  input logic              wake_ready,
  input logic              stop_bit,
  input logic              level_q,
  input logic [WSEL_W-1:0] wsel_q,
  input logic              pin_s,
  input logic [NKEY-1:0]   key_s_n,
  input logic [NKEY-1:0]   key_en,
  input logic              lvl_rel,
  input logic              pin_rise
);
  // R2
  osc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> cpu_hold);

  // R2
  clr_off_chk: assert property (@(posedge clk) disable iff (rst)
    presc_clr |-> !osc_en);

  // R2
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    presc_clr |=> !presc_clr);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_ready |-> (!cpu_hold && !stop_bit && $past(cpu_hold)));

  // R8
  osc_warm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> cpu_hold);

  // R4
  skip_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_bit && !cpu_hold && level_q && lvl_rel) |=> osc_en);

  // R5
  key_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && level_q && !pin_s && ((key_en & ~key_s_n) == '0)) |=> !osc_en);

  // R7
  edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && !level_q && !pin_rise) |=> !osc_en);

  // R10
  wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_hold && cfg_wr) |=> ($stable(level_q) && $stable(wsel_q)));
endmodule

bind deep_sleep_seq deep_sleep_seq_chk #(.NKEY(NKEY), .WSEL_W(WSEL_W)) i_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .osc_en(osc_en),
  .presc_clr(presc_clr), .cpu_hold(cpu_hold), .wake_ready(wake_ready),
  .stop_bit(stop_bit), .level_q(level_q), .wsel_q(wsel_q), .pin_s(pin_s),
  .key_s_n(key_s_n), .key_en(key_en), .lvl_rel(lvl_rel), .pin_rise(pin_rise)
);

// File: tb/test_deep_sleep_seq.sv
module test_deep_sleep_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr, cfg_stop, cfg_level;
  logic [1:0] cfg_wsel;
  logic [3:0] key_en, key_n;
  logic       wake_pin;
  logic       osc_en, presc_clr, cpu_hold, wake_ready, stop_bit;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  deep_sleep_seq i_deep_sleep_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_stop(cfg_stop),
    .cfg_level(cfg_level), .cfg_wsel(cfg_wsel), .key_en(key_en),
    .wake_pin(wake_pin), .key_n(key_n), .osc_en(osc_en),
    .presc_clr(presc_clr), .cpu_hold(cpu_hold), .wake_ready(wake_ready),
    .stop_bit(stop_bit)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic s, input logic lv, input logic [1:0] sel);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_stop = s; cfg_level = lv; cfg_wsel = sel;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Runs until wake_ready; counts warm-up samples, oscillator-off samples and clear pulses.
  task automatic run_warm(output int w, output int s, output int c);
    bit seen = 0;
    w = 0; s = 0; c = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (wake_ready) begin seen = 1; break; end
      if (osc_en && cpu_hold) w++;
      if (!osc_en) s++;
      if (presc_clr) c++;
    end
    chk("R9", "ready seen", seen, 1);
    chk("R9", "hold at ready", cpu_hold, 0);
    chk("R9", "stop bit cleared", stop_bit, 0);
    @(negedge clk);
    chk("R9", "ready one cycle", wake_ready, 0);
  endtask

  task automatic t_reset();
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "cpu_hold", cpu_hold, 0);
    chk("R1", "wake_ready", wake_ready, 0);
    chk("R1", "presc_clr", presc_clr, 0);
    chk("R1", "stop_bit", stop_bit, 0);
  endtask

  task automatic t_skip();
    int w, s, c;
    wake_pin = 1'b1;
    wait_cyc(4);
    write_ctl(1'b1, 1'b1, 2'd0);
    run_warm(w, s, c);
    chk("R4", "osc off samples", s, 0);
    chk("R4", "clear pulses", c, 0);
    chk("R8", "warm-up sel0", w, 256);
    wake_pin = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_level_pin();
    int w, s, c;
    key_en = 4'h0;
    write_ctl(1'b1, 1'b1, 2'd1);
    @(negedge clk);
    chk("R2", "osc off", osc_en, 0);
    chk("R2", "hold on", cpu_hold, 1);
    chk("R2", "clear pulse", presc_clr, 1);
    @(negedge clk);
    chk("R2", "clear pulse ends", presc_clr, 0);
    wait_cyc(20);
    chk("R3", "stays asleep", osc_en, 0);
    wake_pin = 1'b1;
    run_warm(w, s, c);
    chk("R3", "pin release warm-up sel1", w, 1024);
    wake_pin = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_level_key();
    int w, s, c;
    key_en = 4'b0010;
    write_ctl(1'b1, 1'b1, 2'd0);
    key_n[0] = 1'b0;
    wait_cyc(30);
    chk("R5", "masked key no wake", osc_en, 0);
    key_n[1] = 1'b0;
    run_warm(w, s, c);
    chk("R3", "key release warm-up", w, 256);
    key_n = 4'hF;
    wait_cyc(4);
  endtask

  task automatic t_edge();
    int w, s, c;
    wake_pin = 1'b1;
    key_en = 4'hF;
    wait_cyc(4);
    write_ctl(1'b1, 1'b0, 2'd0);
    wait_cyc(20);
    chk("R6", "high pin at entry no wake", osc_en, 0);
    key_n = 4'h0;
    wait_cyc(20);
    chk("R7", "keys ignored in edge style", osc_en, 0);
    key_n = 4'hF;
    wake_pin = 1'b0;
    wait_cyc(20);
    chk("R6", "falling pin no wake", osc_en, 0);
    wake_pin = 1'b1;
    run_warm(w, s, c);
    chk("R6", "rising pin warm-up", w, 256);
    wake_pin = 1'b0;
    key_en = 4'h0;
    wait_cyc(4);
  endtask

  task automatic t_write_ignored();
    int w, s, c;
    key_en = 4'b0001;
    write_ctl(1'b1, 1'b1, 2'd0);
    wait_cyc(5);
    write_ctl(1'b1, 1'b0, 2'd3);
    wait_cyc(5);
    key_n[0] = 1'b0;
    run_warm(w, s, c);
    chk("R10", "style kept, key woke", s < 40, 1);
    chk("R10", "select kept", w, 256);
    key_n = 4'hF;
    key_en = 4'h0;
    wait_cyc(20);
    chk("R9", "stays idle osc", osc_en, 1);
    chk("R9", "stays idle hold", cpu_hold, 0);
  endtask

  task automatic t_long();
    int w, s, c;
    write_ctl(1'b1, 1'b1, 2'd3);
    wait_cyc(10);
    wake_pin = 1'b1;
    run_warm(w, s, c);
    chk("R8", "warm-up sel3", w, 16384);
    wake_pin = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    #(1500000);
    n_bad++;
    $display("FAIL watchdog (R8): actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_stop = 1'b0; cfg_level = 1'b0; cfg_wsel = 2'd0;
    key_en = 4'h0; key_n = 4'hF; wake_pin = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_skip();
    t_level_pin();
    t_level_key();
    t_edge();
    t_write_ignored();
    t_long();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule